// File: doc/BRIEF.md
# IPv4 Routing Header Rewrite Stage

This stage sits in a packet pipeline between the input arbiter and the output queues. Words arrive on a 64-bit data bus with an 8-bit control tag. Each packet begins with one module-header word (control 0xFF), followed by the Ethernet frame. The stage holds the module header and the first five frame words in a local buffer. From them it checks that the packet may be routed, selects a route by longest prefix match, and resolves the next-hop MAC address. It then streams the buffered words out, edited in place, and passes the rest of the packet through unchanged.

A routed packet leaves with new MAC addresses, a TTL lowered by one, and a checksum patched incrementally. Its output port is marked in the module header. A packet that fails a check or misses a table is sent unedited to the CPU queue of the port it arrived on. The route table, the address-resolution table and the per-port MAC addresses are parameters of the block. Backpressure from downstream stalls the stage without loss.

Top module: `ip_hdr_rewrite`

## Requirements
- R1: After reset `out_wr` is 0 and `in_rdy` is 1 until the first packet arrives.
- R2: Module-header word layout (control 0xFF): bits [15:0] are the byte length and bits [16 +: log2(NPORT)] are the input port. Bits [55:48] carry the destination. Bit 2p selects MAC port p and bit 2p+1 selects the CPU queue of port p. On output exactly one of these bits is set. All other header bits pass through unchanged.
- R3: A packet is routed only if all of these hold: its destination MAC equals the MAC of its input port, its EtherType is 0x0800, its version/IHL byte is 0x45, its TTL is at least 2, and the one's-complement sum of its ten IPv4 header halfwords is 0xFFFF.
- R4: Among valid route entries whose masked prefix matches the destination IP, the entry with the longest mask wins. On equal masks the lowest index wins. A next hop of 0 means the destination IP itself is the next hop. With no matching entry the packet goes to the CPU.
- R5: The next hop is looked up in the address-resolution table. A miss sends the packet to the CPU.
- R6: A routed packet's destination MAC becomes the resolved next-hop MAC. Its source MAC becomes the MAC of the chosen output port.
- R7: A routed packet's TTL is lowered by one. Its header checksum is patched by one's-complement incremental update, so the header still sums to 0xFFFF.
- R8: A packet that is not routed goes to the CPU bit of its input port. Every word apart from the destination field is unchanged.
- R9: A packet that ends (nonzero control after the first word) before six words have been received is sent to the CPU unchanged.
- R10: `out_wr` is raised only while `out_rdy` is 1. A low `out_rdy` stalls the stage. Every word leaves exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Incoming data word |
| in_ctrl | input | 8 | Incoming control tag (0xFF header, 0 body, nonzero last) |
| in_wr | input | 1 | Incoming word valid; only while in_rdy is 1 |
| in_rdy | output | 1 | Stage can accept a word this cycle |
| out_data | output | 64 | Outgoing data word |
| out_ctrl | output | 8 | Outgoing control tag |
| out_wr | output | 1 | Outgoing word valid |
| out_rdy | input | 1 | Downstream can accept a word this cycle |

## Verification
Once the sixth buffered word (or an early last word) is accepted, the stage spends one cycle deciding. The first edited word can then transfer on the second clock edge after that acceptance. Each later buffered word follows at every edge where `out_rdy` is high. Body words after the buffer pass through in the same cycle they are accepted. Because a stall can shift any of these by an arbitrary number of cycles, the bench drives and samples half a period away from the edge. It predicts every outgoing word from its own model, compares each word on the clock where `out_wr` is seen, and keeps the expected words in order in a queue.

// File: rtl/ip_hdr_rewrite_pkg.sv
package ip_hdr_rewrite_pkg;

   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_DECIDE  = 2'd1,
      ST_EMIT    = 2'd2,
      ST_PASS    = 2'd3
   } rw_state_e;

   localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
   localparam logic [7:0]  VER_IHL_5  = 8'h45;

   // one's-complement add with end-around carry
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

   // incremental checksum update for one changed halfword
   function automatic logic [15:0] csum_patch(input logic [15:0] hc,
                                              input logic [15:0] old_hw,
                                              input logic [15:0] new_hw);
      return ~oc_add(oc_add(~hc, ~old_hw), new_hw);
   endfunction

endpackage

// File: rtl/ip_hdr_rewrite_lpm.sv
module ip_hdr_rewrite_lpm #(
   parameter int NROUTE = 8,
   parameter int PORT_W = 2,
   parameter logic [NROUTE*32-1:0] RT_PREFIX = '0,
   parameter logic [NROUTE*32-1:0] RT_MASK   = '0,
   parameter logic [NROUTE*32-1:0] RT_NH     = '0,
   parameter logic [NROUTE*8-1:0]  RT_PORT   = '0,
   parameter logic [NROUTE-1:0]    RT_VALID  = '0
) (
   input  logic [31:0]       key,
   output logic              hit,
   output logic [31:0]       nh_ip,
   output logic [PORT_W-1:0] port
);
   localparam int SEL_W = (NROUTE > 1) ? $clog2(NROUTE) : 1;

   if (PORT_W > 8) begin : g_bad_port_w
      $error("route port field is 8 bits wide");
   end

   logic [NROUTE-1:0] match;
   logic [SEL_W-1:0]  best;
   logic [31:0]       best_mask;
   logic [31:0]       nh_raw;

   for (genvar g = 0; g < NROUTE; g++) begin : g_ent
      assign match[g] = RT_VALID[g] &&
                        ((key & RT_MASK[g*32 +: 32]) == RT_PREFIX[g*32 +: 32]);
   end

   always_comb begin
      hit       = 1'b0;
      best      = '0;
      best_mask = '0;
      for (int i = 0; i < NROUTE; i++) begin
         if (match[i] && (!hit || RT_MASK[i*32 +: 32] > best_mask)) begin
            hit       = 1'b1;
            best      = SEL_W'(i);
            best_mask = RT_MASK[i*32 +: 32];
         end
      end
   end

   assign nh_raw = RT_NH[best*32 +: 32];
   assign nh_ip  = (nh_raw == 32'd0) ? key : nh_raw;
   assign port   = RT_PORT[best*8 +: PORT_W];

   // R4: the winning entry must itself match the key
   always_comb begin
      if (hit) a_lpm_match_r4 : assert ((key & best_mask) == RT_PREFIX[best*32 +: 32]);
   end
endmodule

// File: rtl/ip_hdr_rewrite_arp.sv
module ip_hdr_rewrite_arp #(
   parameter int NARP = 8,
   parameter logic [NARP*32-1:0] ARP_IP    = '0,
   parameter logic [NARP*48-1:0] ARP_MAC   = '0,
   parameter logic [NARP-1:0]    ARP_VALID = '0
) (
   input  logic [31:0] key,
   output logic        hit,
   output logic [47:0] mac
);
   logic [NARP-1:0] match;

   for (genvar g = 0; g < NARP; g++) begin : g_ent
      assign match[g] = ARP_VALID[g] && (ARP_IP[g*32 +: 32] == key);
   end

   always_comb begin
      mac = '0;
      for (int i = NARP - 1; i >= 0; i--) begin
         if (match[i]) mac = ARP_MAC[i*48 +: 48];
      end
   end

   assign hit = |match;
endmodule

// File: rtl/ip_hdr_rewrite.sv
module ip_hdr_rewrite
   import ip_hdr_rewrite_pkg::*;
#(
   parameter int NPORT  = 4,
   parameter int DATA_W = 64,
   parameter int CTRL_W = 8,
   parameter int NROUTE = 8,
   parameter int NARP   = 8,
   parameter logic [NPORT*48-1:0] PORT_MAC = {48'h0200_0000_0003, 48'h0200_0000_0002,
                                              48'h0200_0000_0001, 48'h0200_0000_0000},
   parameter logic [NROUTE*32-1:0] RT_PREFIX = {32'h0, 32'h0, 32'h0A01_0000, 32'hAC10_0000,
                                                32'hC0A8_0100, 32'h0A01_0200, 32'h0A01_0000, 32'h0A00_0000},
   parameter logic [NROUTE*32-1:0] RT_MASK = {32'h0, 32'h0, 32'hFFFF_0000, 32'hFFF0_0000,
                                              32'hFFFF_FF00, 32'hFFFF_FF00, 32'hFFFF_0000, 32'hFF00_0000},
   parameter logic [NROUTE*32-1:0] RT_NH = {32'h0, 32'h0, 32'hC0A8_0303, 32'hC0A8_0909,
                                            32'h0, 32'hC0A8_0202, 32'h0, 32'hC0A8_0101},
   parameter logic [NROUTE*8-1:0] RT_PORT = {8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd3, 8'd2, 8'd1},
   parameter logic [NROUTE-1:0] RT_VALID = 8'h3F,
   parameter logic [NARP*32-1:0] ARP_IP = {32'h0, 32'h0, 32'h0, 32'hC0A8_0107,
                                           32'h0A01_0505, 32'hC0A8_0303, 32'hC0A8_0202, 32'hC0A8_0101},
   parameter logic [NARP*48-1:0] ARP_MAC = {48'h0, 48'h0, 48'h0, 48'h00AA_0000_0007,
                                            48'h00AA_0000_0005, 48'h00AA_0000_0003,
                                            48'h00AA_0000_0002, 48'h00AA_0000_0001},
   parameter logic [NARP-1:0] ARP_VALID = 8'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CTRL_W-1:0] in_ctrl,
   input  logic              in_wr,
   output logic              in_rdy,
   output logic [DATA_W-1:0] out_data,
   output logic [CTRL_W-1:0] out_ctrl,
   output logic              out_wr,
   input  logic              out_rdy
);
   localparam int PORT_W    = $clog2(NPORT);
   localparam int HDR_WORDS = 6;
   localparam int CNT_W     = $clog2(HDR_WORDS + 1);
   localparam int DST_LSB   = 48;

   if (DATA_W != 64) begin : g_bad_data_w
      $error("header parsing assumes a 64-bit data word");
   end
   if (NPORT < 2 || NPORT > 4) begin : g_bad_nport
      $error("destination field holds two bits per port in 8 bits");
   end
   if (CTRL_W < 1) begin : g_bad_ctrl_w
      $error("control tag must be at least one bit");
   end

   rw_state_e         st_q;
   logic [DATA_W-1:0] hd_q [HDR_WORDS];
   logic [CTRL_W-1:0] hc_q [HDR_WORDS];
   logic [CNT_W-1:0]  cnt_q, emit_q;
   logic              eop_q;
   logic              fwd_q;
   logic [7:0]        dst_q;
   logic [47:0]       nh_mac_q, src_mac_q;
   logic [7:0]        ttl_new_q;
   logic [15:0]       csum_new_q;

   // fields of the buffered headers
   logic [PORT_W-1:0] in_port;
   logic [47:0]       dmac;
   logic [15:0]       etype, hcs, hsum;
   logic [7:0]        ver_ihl, ttl, proto;
   logic [31:0]       dip;
   logic [15:0]       halves [10];
   logic              is_eop, full_hdr, pkt_ok;
   logic              lpm_hit, arp_hit;
   logic [31:0]       nh_ip;
   logic [PORT_W-1:0] lpm_port;
   logic [47:0]       arp_mac;
   logic [7:0]        dst_d;
   logic [DATA_W-1:0] emit_word;

   assign in_port = hd_q[0][16 +: PORT_W];
   assign dmac    = hd_q[1][63:16];
   assign etype   = hd_q[2][31:16];
   assign ver_ihl = hd_q[2][15:8];
   assign ttl     = hd_q[3][15:8];
   assign proto   = hd_q[3][7:0];
   assign hcs     = hd_q[4][63:48];
   assign dip     = {hd_q[4][15:0], hd_q[5][63:48]};

   assign halves[0] = hd_q[2][15:0];
   for (genvar h = 0; h < 4; h++) begin : g_halves
      assign halves[1+h] = hd_q[3][63-16*h -: 16];
      assign halves[5+h] = hd_q[4][63-16*h -: 16];
   end
   assign halves[9] = hd_q[5][63:48];

   always_comb begin
      hsum = 16'd0;
      for (int k = 0; k < 10; k++) hsum = oc_add(hsum, halves[k]);
   end

   ip_hdr_rewrite_lpm #(
      .NROUTE(NROUTE), .PORT_W(PORT_W), .RT_PREFIX(RT_PREFIX), .RT_MASK(RT_MASK),
      .RT_NH(RT_NH), .RT_PORT(RT_PORT), .RT_VALID(RT_VALID)
   ) u_lpm (
      .key(dip), .hit(lpm_hit), .nh_ip(nh_ip), .port(lpm_port)
   );

   ip_hdr_rewrite_arp #(
      .NARP(NARP), .ARP_IP(ARP_IP), .ARP_MAC(ARP_MAC), .ARP_VALID(ARP_VALID)
   ) u_arp (
      .key(nh_ip), .hit(arp_hit), .mac(arp_mac)
   );

   assign full_hdr = (cnt_q == CNT_W'(HDR_WORDS));
   assign pkt_ok   = full_hdr && (dmac == PORT_MAC[in_port*48 +: 48]) &&
                     (etype == ETYPE_IPV4) && (ver_ihl == VER_IHL_5) &&
                     (ttl > 8'd1) && (hsum == 16'hFFFF) && lpm_hit && arp_hit;

   always_comb begin
      dst_d = '0;
      if (pkt_ok) dst_d[2*lpm_port]     = 1'b1;
      else        dst_d[2*in_port + 1]  = 1'b1;
   end

   assign is_eop = (cnt_q != '0) && (in_ctrl != '0);

   always_comb begin
      emit_word = hd_q[emit_q];
      if (emit_q == '0) emit_word[DST_LSB +: 8] = dst_q;
      if (fwd_q) begin
         unique case (emit_q)
            CNT_W'(1): emit_word = {nh_mac_q, src_mac_q[47:32]};
            CNT_W'(2): emit_word[63:32] = src_mac_q[31:0];
            CNT_W'(3): emit_word[15:8]  = ttl_new_q;
            CNT_W'(4): emit_word[63:48] = csum_new_q;
            default: ;
         endcase
      end
   end

   always_comb begin
      in_rdy   = 1'b0;
      out_wr   = 1'b0;
      out_data = emit_word;
      out_ctrl = hc_q[emit_q];
      unique case (st_q)
         ST_COLLECT: in_rdy = 1'b1;
         ST_EMIT:    out_wr = out_rdy;
         ST_PASS: begin
            in_rdy   = out_rdy;
            out_wr   = in_wr && out_rdy;
            out_data = in_data;
            out_ctrl = in_ctrl;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (st_q == ST_COLLECT && in_wr) begin
         hd_q[cnt_q] <= in_data;
         hc_q[cnt_q] <= in_ctrl;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_COLLECT;
         cnt_q      <= '0;
         emit_q     <= '0;
         eop_q      <= 1'b0;
         fwd_q      <= 1'b0;
         dst_q      <= '0;
         nh_mac_q   <= '0;
         src_mac_q  <= '0;
         ttl_new_q  <= '0;
         csum_new_q <= '0;
      end else begin
         unique case (st_q)
            ST_COLLECT: if (in_wr) begin
               cnt_q <= cnt_q + 1'b1;
               if (is_eop || cnt_q == CNT_W'(HDR_WORDS - 1)) begin
                  st_q  <= ST_DECIDE;
                  eop_q <= is_eop;
               end
            end
            ST_DECIDE: begin
               st_q       <= ST_EMIT;
               emit_q     <= '0;
               fwd_q      <= pkt_ok;
               dst_q      <= dst_d;
               nh_mac_q   <= arp_mac;
               src_mac_q  <= PORT_MAC[lpm_port*48 +: 48];
               ttl_new_q  <= ttl - 8'd1;
               csum_new_q <= csum_patch(hcs, {ttl, proto}, {ttl - 8'd1, proto});
            end
            ST_EMIT: if (out_rdy) begin
               emit_q <= emit_q + 1'b1;
               if (emit_q == cnt_q - 1'b1) begin
                  st_q  <= eop_q ? ST_COLLECT : ST_PASS;
                  cnt_q <= '0;
               end
            end
            ST_PASS: if (in_wr && in_rdy && in_ctrl != '0) st_q <= ST_COLLECT;
            default: st_q <= ST_COLLECT;
         endcase
      end
   end

   // R10: a stalled emit keeps its place
   p_stall_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EMIT && !out_rdy) |=> (st_q == ST_EMIT && $stable(emit_q)));
   // R10: never write into a downstream that is not ready
   p_no_blind_write_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> out_rdy);
   // R2: the emitted module header names exactly one destination
   p_dst_onehot_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EMIT && emit_q == '0 && out_wr) |-> ($countones(out_data[DST_LSB +: 8]) == 1));
   // R3: a routed packet carried a TTL of at least two
   p_fwd_ttl_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EMIT && fwd_q) |-> (hd_q[3][15:8] > 8'd1));
   // R9: a truncated header is never routed
   p_short_cpu_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EMIT && cnt_q != CNT_W'(HDR_WORDS)) |-> !fwd_q);
endmodule

// File: tb/ip_hdr_rewrite_bench.sv
module ip_hdr_rewrite_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] in_data = '0;
   logic [7:0]  in_ctrl = '0;
   logic        in_wr = 1'b0;
   logic        in_rdy;
   logic [63:0] out_data;
   logic [7:0]  out_ctrl;
   logic        out_wr;
   logic        out_rdy = 1'b1;

   always #4 clk = ~clk;   // 125 MHz

   ip_hdr_rewrite u_ip_hdr_rewrite (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
      .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
      .out_rdy(out_rdy)
   );

   // the bench's own view of the tables
   localparam logic [31:0] B_PFX [8] = '{32'h0A000000, 32'h0A010000, 32'h0A010200, 32'hC0A80100,
                                         32'hAC100000, 32'h0A010000, 32'h0, 32'h0};
   localparam logic [31:0] B_MSK [8] = '{32'hFF000000, 32'hFFFF0000, 32'hFFFFFF00, 32'hFFFFFF00,
                                         32'hFFF00000, 32'hFFFF0000, 32'h0, 32'h0};
   localparam logic [31:0] B_NH  [8] = '{32'hC0A80101, 32'h0, 32'hC0A80202, 32'h0,
                                         32'hC0A80909, 32'hC0A80303, 32'h0, 32'h0};
   localparam int          B_RP  [8] = '{1, 2, 3, 0, 1, 0, 0, 0};
   localparam logic [31:0] B_AIP [5] = '{32'hC0A80101, 32'hC0A80202, 32'hC0A80303,
                                         32'h0A010505, 32'hC0A80107};
   localparam logic [47:0] B_AMAC[5] = '{48'h00AA00000001, 48'h00AA00000002, 48'h00AA00000003,
                                         48'h00AA00000005, 48'h00AA00000007};
   localparam logic [47:0] B_PMAC[4] = '{48'h020000000000, 48'h020000000001,
                                         48'h020000000002, 48'h020000000003};

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit stress = 0;

   logic [71:0] in_q[$];
   logic [71:0] exp_q[$];
   string       tag_q[$];

   logic [63:0] pw [0:31];
   logic [7:0]  pc [0:31];
   int          pn;

   function automatic logic [15:0] ip_sum(input logic [63:0] a2, a3, a4, a5);
      int s;
      s = int'(a2[15:0]) + int'(a3[63:48]) + int'(a3[47:32]) + int'(a3[31:16]) + int'(a3[15:0]) +
          int'(a4[63:48]) + int'(a4[47:32]) + int'(a4[31:16]) + int'(a4[15:0]) + int'(a5[63:48]);
      while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >>> 16);
      return s[15:0];
   endfunction

   task automatic build(input int inp, input logic [47:0] dmac, input logic [15:0] et,
                        input logic [7:0] ttl, input logic [31:0] dip, input int extra,
                        input bit badcs, input int cut);
      pn = 6 + extra;
      pw[1] = {dmac, 16'h0000};
      pw[2] = {32'h1234_5678, et, 8'h45, 8'h00};
      pw[3] = {16'(pn*8 - 22), 16'h1C46, 16'h4000, ttl, 8'h11};
      pw[4] = {16'h0000, 32'hC0A8_0A0A, dip[31:16]};
      pw[5] = {dip[15:0], 48'hA1B2_C3D4_E5F6 + 48'(inp)};
      for (int i = 6; i < pn; i++) pw[i] = 64'hDEAD_0000_0000_0000 + 64'(i * 7 + inp);
      pw[4][63:48] = ~ip_sum(pw[2], pw[3], pw[4], pw[5]) ^ (badcs ? 16'h0001 : 16'h0000);
      if (cut > 0) pn = cut;
      pw[0] = {16'h0000, 16'h0000, 16'(inp), 16'(pn*8)};
      for (int i = 0; i < pn; i++) pc[i] = 8'h00;
      pc[0] = 8'hFF;
      pc[pn-1] = 8'h40;
   endtask

   // predicts the outgoing words and queues the packet
   task automatic send(input string tag);
      logic [63:0] e [0:31];
      int inp, best, ai, port;
      bit ok;
      logic [31:0] dip, nh;
      inp = int'(pw[0][17:16]);
      ok = 0; best = -1; ai = -1; port = 0;
      for (int i = 0; i < pn; i++) e[i] = pw[i];
      if (pn >= 6) begin
         dip = {pw[4][15:0], pw[5][63:48]};
         for (int r = 0; r < 6; r++)
            if ((dip & B_MSK[r]) == B_PFX[r] && (best < 0 || B_MSK[r] > B_MSK[best])) best = r;
         if (best >= 0) begin
            nh = (B_NH[best] == 32'h0) ? dip : B_NH[best];
            port = B_RP[best];
            for (int a = 0; a < 5; a++) if (ai < 0 && B_AIP[a] == nh) ai = a;
         end
         ok = (pw[1][63:16] == B_PMAC[inp]) && (pw[2][31:16] == 16'h0800) &&
              (pw[2][15:8] == 8'h45) && (pw[3][15:8] > 8'd1) &&
              (ip_sum(pw[2], pw[3], pw[4], pw[5]) == 16'hFFFF) && best >= 0 && ai >= 0;
      end
      if (ok) begin
         e[0][55:48] = 8'(1 << (2*port));
         e[1] = {B_AMAC[ai], B_PMAC[port][47:32]};
         e[2][63:32] = B_PMAC[port][31:0];
         e[3][15:8] = pw[3][15:8] - 8'd1;
         e[4][63:48] = 16'h0000;
         e[4][63:48] = ~ip_sum(e[2], e[3], e[4], e[5]);
      end else begin
         e[0][55:48] = 8'(1 << (2*inp + 1));
      end
      for (int i = 0; i < pn; i++) begin
         in_q.push_back({pc[i], pw[i]});
         exp_q.push_back({pc[i], e[i]});
         tag_q.push_back(i == 0 ? {tag, "/R2"} : tag);
      end
   endtask

   task automatic step();
      logic [71:0] x;
      string t;
      @(negedge clk);
      cyc++;
      out_rdy = stress ? !((cyc % 7) == 3 || (cyc % 11) == 5) : 1'b1;
      #1;
      if (in_q.size() != 0 && in_rdy && (cyc % 5) != 2) begin
         x = in_q.pop_front();
         {in_ctrl, in_data} = x;
         in_wr = 1'b1;
      end else begin
         in_wr = 1'b0;
      end
      #1;
      if (out_wr) begin
         checks++;
         if (!out_rdy) begin
            errors++;
            $display("FAIL R10 write while not ready: got out_wr=1 expected 0");
         end else if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 extra word: got %h_%h expected none", out_ctrl, out_data);
         end else begin
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({out_ctrl, out_data} !== x) begin
               errors++;
               $display("FAIL %s word: got %h_%h expected %h_%h", t, out_ctrl, out_data,
                        x[71:64], x[63:0]);
            end
         end
      end
   endtask

   task automatic load_set();
      build(0, B_PMAC[0], 16'h0800, 8'd64, 32'h0A010209, 2, 0, 0); send("R6");
      build(1, B_PMAC[1], 16'h0800, 8'd2,  32'h0A090909, 0, 0, 0); send("R7");
      build(2, B_PMAC[2], 16'h0800, 8'd17, 32'h0A010505, 1, 0, 0); send("R4");
      build(3, B_PMAC[3], 16'h0800, 8'd9,  32'hC0A80107, 3, 0, 0); send("R4");
      build(0, B_PMAC[0], 16'h0800, 8'd30, 32'hAC100101, 1, 0, 0); send("R5");
      build(1, B_PMAC[1], 16'h0800, 8'd30, 32'h08080808, 2, 0, 0); send("R8");
      build(2, B_PMAC[0], 16'h0800, 8'd30, 32'h0A010209, 0, 0, 0); send("R3");
      build(3, B_PMAC[3], 16'h0800, 8'd1,  32'h0A010209, 1, 0, 0); send("R3");
      build(0, B_PMAC[0], 16'h0800, 8'd0,  32'h0A010209, 1, 0, 0); send("R3");
      build(1, B_PMAC[1], 16'h0800, 8'd40, 32'h0A010209, 1, 1, 0); send("R3");
      build(2, B_PMAC[2], 16'h0806, 8'd40, 32'h0A010209, 1, 0, 0); send("R3");
      build(3, B_PMAC[3], 16'h0800, 8'd40, 32'h0A010209, 0, 0, 4); send("R9");
      build(1, B_PMAC[1], 16'h0800, 8'd40, 32'h0A010209, 0, 0, 2); send("R9");
      build(2, B_PMAC[2], 16'h0800, 8'd255, 32'h0A0102FE, 4, 0, 0); send("R7");
   endtask

   task automatic drain();
      int n = 0;
      while ((in_q.size() != 0 || exp_q.size() != 0) && n < 5000) begin
         step();
         n++;
      end
      repeat (10) step();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step();
      checks++;
      if (out_wr !== 1'b0 || in_rdy !== 1'b1) begin
         errors++;
         $display("FAIL R1 idle after reset: got wr=%b rdy=%b expected wr=0 rdy=1", out_wr, in_rdy);
      end
      load_set();
      drain();
      stress = 1;
      load_set();
      drain();
      checks++;
      if (exp_q.size() != 0 || in_q.size() != 0) begin
         errors++;
         $display("FAIL R10 words lost: got %0d pending expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1600000;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule